// File: doc/BRIEF.md
# Digital Clock Core with Time Setting and Hourly Chime

This block keeps the time of day for a small digital clock. It runs from one reference clock at 1024 Hz and an asynchronous active-low reset. A free-running binary divider gives a one-cycle enable once per second and a square wave at half the reference rate. Seconds, minutes and hours are kept as pairs of BCD digits. Seconds and minutes count from 00 to 59, and hours count from 00 to 23.

Two level inputs are used to set the time. While the hour-set input is held, the hour pair steps once per second instead of waiting for a carry from the minutes. The minute-set input does the same for the minute pair. While minute-set is held, the minutes give no carry into the hours.

A buzzer output sounds a countdown before every hour. In minute 59 it gives a lower pitch on four odd seconds, then a higher pitch on the last second of the hour. The tone select is held in a register so that the output only switches between clean tone sources. All logic is in the reference clock domain. The divider width is a parameter so that a bench can run the clock faster.

Top module: `clock_chime`

## Requirements
- R1: While rst_n is low, all six time digits, the divider and the buzzer tone select are zero. As a result, buzz is low at any time clk is low.
- R2: The second-tick enable is active in the cycle where the DIV_BITS-bit divider holds all ones. That is once every 2**DIV_BITS cycles. The first tick comes 2**DIV_BITS rising edges after reset is released. The seconds change only on a tick.
- R3: Each BCD pair steps as follows. The units digit goes from 9 to 0 and the tens digit goes up by one. Seconds go from 59 to 00. No digit ever leaves its legal range: seconds and minutes 00..59, hours 00..23.
- R4: With neither set input held, the minutes go up by one on the tick where seconds wrap. The hours go up by one on the tick where the time goes from mm:ss 59:59 to 00:00. Hours go from 23 to 00.
- R5: While hour_set is high, the hours go up by one on every tick. This holds whatever the minutes and seconds are.
- R6: While min_set is high, the minutes go up by one on every tick. A wrap from 59 to 00 in this state does not advance the hours.
- R7: Tone select code 1 is loaded on the edge after the time shows minute 59 with seconds 51, 53, 55 or 57. During code 1, buzz equals divider bit 0, a square wave at half the clk rate.
- R8: Tone select code 2 is loaded on the edge after the time shows 59:59. During code 2, buzz equals clk.
- R9: Tone select code 0 applies at all other times, and buzz is then low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1024 Hz reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hour_set | input | 1 | Hold high to step the hours once per second |
| min_set | input | 1 | Hold high to step the minutes once per second |
| hr_t | output | 4 | Hours tens digit (BCD) |
| hr_u | output | 4 | Hours units digit (BCD) |
| min_t | output | 4 | Minutes tens digit (BCD) |
| min_u | output | 4 | Minutes units digit (BCD) |
| sec_t | output | 4 | Seconds tens digit (BCD) |
| sec_u | output | 4 | Seconds units digit (BCD) |
| buzz | output | 1 | Chime output |

## Verification
The digits change on the same rising edge as the tick, so they are due one edge after the divider reaches all ones. The tone select follows the displayed time one edge later, because it is registered from the digits. The reference model in the bench updates its time and its tone select in that same order on every edge. The bench compares all outputs a quarter period after each rising edge. At that point clk is high and the divider has settled, so each expected buzz value has exactly one correct answer.

// File: rtl/clock_chime.sv
module clock_chime #(
  parameter int DIV_BITS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hour_set,
  input  logic       min_set,
  output logic [3:0] hr_t,
  output logic [3:0] hr_u,
  output logic [3:0] min_t,
  output logic [3:0] min_u,
  output logic [3:0] sec_t,
  output logic [3:0] sec_u,
  output logic       buzz
);
  localparam logic [1:0] TONE_OFF  = 2'd0;
  localparam logic [1:0] TONE_LOW  = 2'd1;
  localparam logic [1:0] TONE_HIGH = 2'd2;

  logic [DIV_BITS-1:0] div;
  logic [1:0] tone_sel;
  logic tick, sec_wrap, min_inc, min_wrap, hr_inc, min59, sec_top;
  logic [1:0] tone_nxt;

  assign tick     = &div;
  assign sec_wrap = tick && sec_t == 4'd5 && sec_u == 4'd9;
  assign min59    = min_t == 4'd5 && min_u == 4'd9;
  assign min_inc  = min_set ? tick : sec_wrap;
  assign min_wrap = min_inc && min59 && !min_set;
  assign hr_inc   = hour_set ? tick : min_wrap;
  assign sec_top  = min59 && sec_t == 4'd5;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) div <= '0;
    else        div <= div + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec_t <= '0; sec_u <= '0;
    end else if (tick) begin
      if (sec_u == 4'd9) begin
        sec_u <= '0;
        sec_t <= (sec_t == 4'd5) ? 4'd0 : sec_t + 4'd1;
      end else sec_u <= sec_u + 4'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      min_t <= '0; min_u <= '0;
    end else if (min_inc) begin
      if (min_u == 4'd9) begin
        min_u <= '0;
        min_t <= (min_t == 4'd5) ? 4'd0 : min_t + 4'd1;
      end else min_u <= min_u + 4'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hr_t <= '0; hr_u <= '0;
    end else if (hr_inc) begin
      if (hr_t == 4'd2 && hr_u == 4'd3) begin
        hr_t <= '0; hr_u <= '0;
      end else if (hr_u == 4'd9) begin
        hr_u <= '0; hr_t <= hr_t + 4'd1;
      end else hr_u <= hr_u + 4'd1;
    end

  always_comb begin
    tone_nxt = TONE_OFF;
    if (sec_top && sec_u == 4'd9)                 tone_nxt = TONE_HIGH;
    else if (sec_top && sec_u[0] && sec_u != 4'd9) tone_nxt = TONE_LOW;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tone_sel <= TONE_OFF;
    else        tone_sel <= tone_nxt;

  assign buzz = (tone_sel == TONE_LOW  && div[0]) ||
                (tone_sel == TONE_HIGH && clk);
endmodule

// File: rtl/clock_chime_chk.sv
module clock_chime_chk #(
  parameter int DIV_BITS = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hour_set,
  input logic [DIV_BITS-1:0] div,
  input logic [1:0]          tone_sel,
  input logic [3:0]          hr_t,
  input logic [3:0]          hr_u,
  input logic [3:0]          min_t,
  input logic [3:0]          min_u,
  input logic [3:0]          sec_t,
  input logic [3:0]          sec_u
);
  p_sec_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_t <= 4'd5 && sec_u <= 4'd9);

  p_min_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    min_t <= 4'd5 && min_u <= 4'd9);

  p_hr_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hr_t < 4'd2 || (hr_t == 4'd2 && hr_u <= 4'd3));

  p_sec_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_u != $past(sec_u)) |-> ($past(div) == '1));

  p_hset_steps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hour_set && div == '1) |=> (hr_u != $past(hr_u) || hr_t != $past(hr_t)));

  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(min_t) == 4'd5 && $past(min_u) == 4'd9) |-> tone_sel == 2'd0);
endmodule

bind clock_chime clock_chime_chk #(.DIV_BITS(DIV_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hour_set(hour_set), .div(div),
  .tone_sel(tone_sel), .hr_t(hr_t), .hr_u(hr_u), .min_t(min_t),
  .min_u(min_u), .sec_t(sec_t), .sec_u(sec_u)
);

// File: tb/sim_clock_chime.sv
module sim_clock_chime;
  localparam int CLK_P = 10;
  localparam int DIVB  = 4;
  localparam int NDIV  = 1 << DIVB;

  logic clk = 1'b0, rst_n = 1'b0, hour_set = 1'b0, min_set = 1'b0;
  logic [3:0] hr_t, hr_u, min_t, min_u, sec_t, sec_u;
  logic buzz;

  int errors = 0, checks = 0;
  int m_cnt = 0, m_sec = 0, m_min = 0, m_hr = 0, m_mode = 0;
  int low_seen = 0, high_seen = 0, hr_wraps = 0;
  bit done = 0;

  clock_chime #(.DIV_BITS(DIVB)) u0 (
    .clk(clk), .rst_n(rst_n), .hour_set(hour_set), .min_set(min_set),
    .hr_t(hr_t), .hr_u(hr_u), .min_t(min_t), .min_u(min_u),
    .sec_t(sec_t), .sec_u(sec_u), .buzz(buzz));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sec = 0; m_min = 0; m_hr = 0; m_mode = 0;
    end else begin
      bit tick, minc, hinc;
      if (m_min == 59 && m_sec == 59) m_mode = 2;
      else if (m_min == 59 && (m_sec == 51 || m_sec == 53 || m_sec == 55 || m_sec == 57)) m_mode = 1;
      else m_mode = 0;
      tick = (m_cnt == NDIV - 1);
      m_cnt = (m_cnt + 1) % NDIV;
      if (tick) begin
        minc = min_set ? 1'b1 : (m_sec == 59);
        hinc = hour_set ? 1'b1 : (minc && !min_set && m_min == 59);
        m_sec = (m_sec + 1) % 60;
        if (minc) m_min = (m_min + 1) % 60;
        if (hinc) begin
          if (m_hr == 23) hr_wraps++;
          m_hr = (m_hr + 1) % 24;
        end
      end
    end
    #2;
    check("R2 R3 seconds", sec_t * 10 + sec_u, m_sec);
    check("R4 R6 minutes", min_t * 10 + min_u, m_min);
    check("R4 R5 hours", hr_t * 10 + hr_u, m_hr);
    if (m_mode == 1) low_seen++;
    if (m_mode == 2) high_seen++;
    check(m_mode == 1 ? "R7 low tone" : m_mode == 2 ? "R8 high beep" : "R9 quiet",
          int'(buzz), m_mode == 1 ? (m_cnt & 1) : m_mode == 2 ? 1 : 0);
  end

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    run(3);
    check("R1 reset digits", hr_t + hr_u + min_t + min_u + sec_t + sec_u, 0);
    check("R1 reset buzz", int'(buzz), 0);
    rst_n = 1'b1;
    run(NDIV - 1);
    check("R2 no tick before period", sec_u, 0);
    run(1);
    check("R2 first tick", sec_u, 1);
    run(62 * NDIV);
    min_set = 1'b1;
    run(60 * NDIV);
    min_set = 1'b0;
    hour_set = 1'b1;
    run(25 * NDIV);
    min_set = 1'b1;
    run(3 * NDIV);
    hour_set = 1'b0;
    while (m_min != 58) @(negedge clk);
    min_set = 1'b0;
    run(130 * NDIV);
    rst_n = 1'b0;
    run(2);
    check("R1 mid-run reset", hr_t + hr_u + min_t + min_u + sec_t + sec_u, 0);
    rst_n = 1'b1;
    run(3 * NDIV);
    check("R4 hour wrap seen", int'(hr_wraps > 0), 1);
    check("R7 low tone seen", int'(low_seen > 0), 1);
    check("R8 high beep seen", int'(high_seen > 0), 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule